// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer of a small processor for taking an interrupt and for returning from one. When a maskable request qualifies at an instruction boundary, the block captures the processor context: program counter, index registers X and Y, accumulators A and B, and the condition code byte. It writes these nine bytes one per clock to a byte-wide stack in memory. The stack grows downward. The block then reads a 16-bit handler address from a fixed vector location and sets the interrupt mask bit in the condition code byte it hands back.

On a return strobe, the block pulls the nine bytes back in the reverse order. The stack pointer ends where it stood before entry. The processor then receives the saved context, including the saved mask bits. The processor core loads the block's context outputs whenever `ctx_wr_o` pulses. The request source clears its flag on `ack_o`.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset `busy_o`, `ack_o`, `ctx_wr_o`, `mem_we_o` and `mem_re_o` are 0 and `sp_o` equals the parameter `SP_INIT` (default 16'h0800).
- R2: An entry starts only in a cycle where the block is idle, `inst_done_i` is 1, bit `I_BIT` (default 4) of `ccr_i` is 0, and `irq_req_ni` was low at the previous clock edge and is still low. A one-cycle low pulse, a masked request, and a request raised outside an instruction boundary all start nothing.
- R3: Entry writes nine bytes on consecutive clocks in this order: PC[7:0], PC[15:8], Y[7:0], Y[15:8], X[7:0], X[15:8], A, B, CCR. The values are those on the inputs in the accepting cycle. Write and read are never asserted together.
- R4: Each push writes to the stack pointer minus one, and the pointer takes that address. After entry `sp_o` is nine below its value before entry.
- R5: The stored CCR byte holds the mask bit as it was before entry. In the `ack_o` cycle `ccr_o` is that CCR with bit `I_BIT` set and all other bits unchanged.
- R6: After the pushes the block reads `VEC_ADDR` (default 16'hFFF2) and then `VEC_ADDR`+1. Memory returns read data one clock after the read. The first byte becomes PC[15:8] and the second PC[7:0] on `pc_o`.
- R7: `busy_o` is high for exactly 12 cycles, starting the cycle after acceptance. In the following cycle `ack_o` and `ctx_wr_o` pulse high for one cycle, `busy_o` is low, and `pc_o` shows the vector while X, Y, A and B are unchanged.
- R8: While `busy_o` is high a request is ignored, and the block makes no memory access outside the sequences described.
- R9: On an idle-cycle `rti_i` pulse the block reads nine bytes on consecutive clocks, starting at `sp_o` and incrementing after each read. The bytes come in the reverse of push order. `sp_o` is back at its pre-entry value when done.
- R10: When the pull completes, `ctx_wr_o` pulses for one cycle with `ack_o` low. All six context outputs, including both mask bits (bits 4 and 6 of the CCR), then carry the pulled values.
- R11: If `rti_i` and a qualifying request fall in the same idle cycle, the return runs first. The request is accepted in the cycle `ctx_wr_o` pulses, if it still qualifies then.
- R12: With `sp_load_i` high in an idle cycle, `sp_o` takes `sp_din_i` at the next edge, and no sequence starts in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_ni | input | 1 | Maskable interrupt request, active low |
| inst_done_i | input | 1 | Current instruction has completed |
| rti_i | input | 1 | Return-from-interrupt strobe |
| sp_load_i | input | 1 | Load stack pointer |
| sp_din_i | input | AW | New stack pointer value |
| pc_i | input | 2*DW | Program counter (return address) |
| x_i | input | 2*DW | Index register X |
| y_i | input | 2*DW | Index register Y |
| a_i | input | DW | Accumulator A |
| b_i | input | DW | Accumulator B |
| ccr_i | input | DW | Condition code byte |
| pc_o | output | 2*DW | Program counter to load |
| x_o | output | 2*DW | X to load |
| y_o | output | 2*DW | Y to load |
| a_o | output | DW | A to load |
| b_o | output | DW | B to load |
| ccr_o | output | DW | CCR to load |
| ctx_wr_o | output | 1 | Context outputs valid, load them |
| ack_o | output | 1 | Entry done, clear request flag |
| busy_o | output | 1 | Sequence in progress |
| sp_o | output | AW | Stack pointer |
| mem_addr_o | output | AW | Memory address |
| mem_we_o | output | 1 | Memory write |
| mem_re_o | output | 1 | Memory read |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one clock after read |

## Verification
A return strobe and a qualifying request can land in the same idle cycle. To provoke this, the request line is held low while the mask bit is set. The mask is then cleared in the same cycle that `rti_i` pulses. A scoreboard of expected memory operations, queued before the stimulus, judges the outcome. It must see nine stack reads, then nine fresh writes and two vector reads, with nothing interleaved. The restored context must be correct in the `ctx_wr_o` cycle that separates the two sequences.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int unsigned CTX_BYTES = 9;
  localparam int unsigned CCR_IDX   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC_H,
    ST_VEC_L,
    ST_VEC_DONE,
    ST_POP
  } seq_state_e;
endpackage

// File: rtl/irq_ctx_sp.sv
module irq_ctx_sp #(
  parameter int unsigned     AW      = 16,
  parameter logic [AW-1:0]   SP_INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] din_i,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_dec_o
);
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_INIT;
    else if (load_i) sp_q <= din_i;
    else if (dec_i)  sp_q <= sp_q - AW'(1);
    else if (inc_i)  sp_q <= sp_q + AW'(1);
  end

  assign sp_o     = sp_q;
  assign sp_dec_o = sp_q - AW'(1);
endmodule

// File: rtl/irq_ctx_req.sv
module irq_ctx_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic inst_done_i,
  input  logic mask_i,
  input  logic idle_i,
  output logic take_o
);
  logic req_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_low_q <= 1'b0;
    else         req_low_q <= ~req_ni;
  end

  // low at the last edge and still low: at least one full clock
  assign take_o = idle_i & inst_done_i & ~mask_i & req_low_q & ~req_ni;
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs #(
  parameter int unsigned NB       = 9,
  parameter int unsigned DW       = 8,
  parameter int unsigned IW       = 4,
  parameter int unsigned SET_IDX  = 8,
  parameter logic [7:0]  SET_MASK = 8'h10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snap_en_i,
  input  logic [NB*DW-1:0] snap_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             set_en_i,
  output logic [NB*DW-1:0] q_o
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [DW-1:0] r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              r_q <= '0;
      else if (snap_en_i)                       r_q <= snap_i[g*DW +: DW];
      else if (wr_en_i && wr_idx_i == IW'(g))   r_q <= wr_data_i;
      else if (set_en_i && SET_IDX == g)        r_q <= r_q | DW'(SET_MASK);
    end

    assign q_o[g*DW +: DW] = r_q;
  end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 8,
  parameter logic [AW-1:0] SP_INIT  = 16'h0800,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFF2,
  parameter int unsigned   I_BIT    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_req_ni,
  input  logic            inst_done_i,
  input  logic            rti_i,
  input  logic            sp_load_i,
  input  logic [AW-1:0]   sp_din_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [2*DW-1:0] x_i,
  input  logic [2*DW-1:0] y_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [DW-1:0]   ccr_i,
  output logic [2*DW-1:0] pc_o,
  output logic [2*DW-1:0] x_o,
  output logic [2*DW-1:0] y_o,
  output logic [DW-1:0]   a_o,
  output logic [DW-1:0]   b_o,
  output logic [DW-1:0]   ccr_o,
  output logic            ctx_wr_o,
  output logic            ack_o,
  output logic            busy_o,
  output logic [AW-1:0]   sp_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i
);
  localparam int unsigned WW  = 2 * DW;
  localparam int unsigned CW  = $clog2(CTX_BYTES + 1);
  localparam int unsigned CTW = CTX_BYTES * DW;
  localparam logic [CW-1:0] CNT_LAST = CW'(CTX_BYTES - 1);
  localparam logic [CW-1:0] CNT_END  = CW'(CTX_BYTES);

  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic          ack_q, ctx_wr_q;

  logic          idle, take, start_rti;
  logic          push, pop_rd, pop_cap;
  logic [AW-1:0] sp_dec;
  logic [CTW-1:0] ctx_q, snap;
  logic          wr_en;
  logic [CW-1:0] wr_idx;

  assign idle      = (state_q == ST_IDLE);
  assign start_rti = idle & ~sp_load_i & rti_i;
  assign push      = (state_q == ST_PUSH);
  assign pop_rd    = (state_q == ST_POP) && (cnt_q <= CNT_LAST);
  assign pop_cap   = (state_q == ST_POP) && (cnt_q != '0);

  irq_ctx_req u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ni      (irq_req_ni),
    .inst_done_i (inst_done_i),
    .mask_i      (ccr_i[I_BIT]),
    .idle_i      (idle & ~sp_load_i & ~rti_i),
    .take_o      (take)
  );

  irq_ctx_sp #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (idle & sp_load_i),
    .din_i    (sp_din_i),
    .dec_i    (push),
    .inc_i    (pop_rd),
    .sp_o     (sp_o),
    .sp_dec_o (sp_dec)
  );

  assign snap   = {ccr_i, b_i, a_i, x_i, y_i, pc_i};
  assign wr_en  = pop_cap | (state_q == ST_VEC_L) | (state_q == ST_VEC_DONE);
  assign wr_idx = pop_cap ? (CNT_END - cnt_q) :
                  (state_q == ST_VEC_L) ? CW'(1) : CW'(0);

  irq_ctx_regs #(
    .NB       (CTX_BYTES),
    .DW       (DW),
    .IW       (CW),
    .SET_IDX  (CCR_IDX),
    .SET_MASK (8'(1 << I_BIT))
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snap_en_i (take),
    .snap_i    (snap),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (mem_rdata_i),
    .set_en_i  (state_q == ST_VEC_DONE),
    .q_o       (ctx_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
      ctx_wr_q <= 1'b0;
    end else begin
      ack_q    <= 1'b0;
      ctx_wr_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_rti) state_q <= ST_POP;
          else if (take) state_q <= ST_PUSH;
        end
        ST_PUSH: begin
          if (cnt_q == CNT_LAST) state_q <= ST_VEC_H;
          else                   cnt_q   <= cnt_q + CW'(1);
        end
        ST_VEC_H: state_q <= ST_VEC_L;
        ST_VEC_L: state_q <= ST_VEC_DONE;
        ST_VEC_DONE: begin
          state_q  <= ST_IDLE;
          ack_q    <= 1'b1;
          ctx_wr_q <= 1'b1;
        end
        ST_POP: begin
          if (cnt_q == CNT_END) begin
            state_q  <= ST_IDLE;
            ctx_wr_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PUSH:  mem_addr_o = sp_dec;
      ST_VEC_H: mem_addr_o = VEC_ADDR;
      ST_VEC_L: mem_addr_o = VEC_ADDR + AW'(1);
      default:  mem_addr_o = sp_o;
    endcase
  end

  assign mem_we_o    = push;
  assign mem_re_o    = pop_rd | (state_q == ST_VEC_H) | (state_q == ST_VEC_L);
  assign mem_wdata_o = DW'(ctx_q >> (int'(cnt_q) * DW));

  assign pc_o     = ctx_q[0*DW +: WW];
  assign y_o      = ctx_q[2*DW +: WW];
  assign x_o      = ctx_q[4*DW +: WW];
  assign a_o      = ctx_q[6*DW +: DW];
  assign b_o      = ctx_q[7*DW +: DW];
  assign ccr_o    = ctx_q[CCR_IDX*DW +: DW];
  assign ack_o    = ack_q;
  assign ctx_wr_o = ctx_wr_q;
  assign busy_o   = ~idle;
endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 8,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFF2,
  parameter int unsigned   I_BIT    = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2*DW-1:0] pc_o,
  input logic [DW-1:0]   ccr_o,
  input logic            ctx_wr_o,
  input logic            ack_o,
  input logic            busy_o,
  input logic [AW-1:0]   sp_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            mem_we_o,
  input logic            mem_re_o,
  input logic [DW-1:0]   mem_rdata_i
);
  AST_NO_WR_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R3

  AST_PUSH_PREDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(mem_addr_o)); // R4

  AST_POP_POSTINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && mem_addr_o == sp_o && mem_addr_o != VEC_ADDR
     && mem_addr_o != VEC_ADDR + AW'(1)) |=> sp_o == $past(sp_o) + AW'(1)); // R9

  AST_ACK_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ccr_o[I_BIT]); // R5

  AST_ACK_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> pc_o == {$past(mem_rdata_i, 2), $past(mem_rdata_i)}); // R6

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R7

  AST_ACK_WITH_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ctx_wr_o && !busy_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || mem_re_o)); // R8

  AST_END_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ctx_wr_o); // R10
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(
  .AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR), .I_BIT(I_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_o        (pc_o),
  .ccr_o       (ccr_o),
  .ctx_wr_o    (ctx_wr_o),
  .ack_o       (ack_o),
  .busy_o      (busy_o),
  .sp_o        (sp_o),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/irq_ctx_seq_tb_top.sv
module irq_ctx_seq_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, irq_n, inst_done, rti, sp_load;
  logic [15:0] sp_din, pc_i, x_i, y_i;
  logic [7:0]  a_i, b_i, ccr_i;
  logic [15:0] pc_o, x_o, y_o, sp_o, mem_addr_o;
  logic [7:0]  a_o, b_o, ccr_o, mem_wdata_o, mem_rdata;
  logic        ctx_wr_o, ack_o, busy_o, mem_we_o, mem_re_o;

  irq_ctx_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_ni(irq_n), .inst_done_i(inst_done),
    .rti_i(rti), .sp_load_i(sp_load), .sp_din_i(sp_din),
    .pc_i(pc_i), .x_i(x_i), .y_i(y_i), .a_i(a_i), .b_i(b_i), .ccr_i(ccr_i),
    .pc_o(pc_o), .x_o(x_o), .y_o(y_o), .a_o(a_o), .b_o(b_o), .ccr_o(ccr_o),
    .ctx_wr_o(ctx_wr_o), .ack_o(ack_o), .busy_o(busy_o), .sp_o(sp_o),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: synchronous read
  logic [7:0] mem [logic [15:0]];
  always @(posedge clk) begin
    if (mem_re_o) mem_rdata <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 8'h00;
    if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
  end

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } op_t;
  op_t q[$];

  task automatic exp_op(input bit we, input logic [15:0] a, input logic [7:0] d,
                        input string r);
    q.push_back('{we, a, d, r});
  endtask

  task automatic exp_entry(input logic [15:0] sp0, input logic [15:0] pc,
                           input logic [15:0] x, input logic [15:0] y,
                           input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c);
    logic [7:0] bytes [9];
    bytes = '{pc[7:0], pc[15:8], y[7:0], y[15:8], x[7:0], x[15:8], a, b, c};
    for (int k = 0; k < 9; k++) exp_op(1'b1, sp0 - 16'(k + 1), bytes[k], "R3");
    exp_op(1'b0, 16'hFFF2, 8'h00, "R6");
    exp_op(1'b0, 16'hFFF3, 8'h00, "R6");
  endtask

  task automatic exp_rti(input logic [15:0] sp0);
    for (int k = 0; k < 9; k++) exp_op(1'b0, sp0 + 16'(k), 8'h00, "R9");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    op_t e;
    if (rst_n && (mem_we_o || mem_re_o)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", {7'd0, mem_we_o, mem_addr_o, mem_wdata_o}, 32'h0);
      end else begin
        e = q.pop_front();
        chk(mem_we_o == e.we && mem_addr_o == e.addr && (!e.we || mem_wdata_o == e.data),
            e.req, {7'd0, mem_we_o, mem_addr_o, mem_wdata_o},
            {7'd0, e.we, e.addr, e.we ? e.data : 8'h00});
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_entry(input logic [15:0] exp_sp, input logic [7:0] exp_ccr,
                           input logic [15:0] ex, input logic [15:0] ey);
    int bc;
    bc = 0;
    do @(negedge clk); while (!busy_o);
    while (busy_o) begin
      bc++;
      if (mem_re_o && mem_addr_o == 16'hFFF2) irq_n = 1'b1; // held low while busy: R8
      @(negedge clk);
    end
    chk(ack_o == 1'b1, "R7 ack", 32'(ack_o), 32'h1);
    chk(ctx_wr_o == 1'b1, "R7 ctx_wr", 32'(ctx_wr_o), 32'h1);
    chk(bc == 12, "R7 busy length", 32'(bc), 32'd12);
    chk(pc_o == 16'h1234, "R6 vector", 32'(pc_o), 32'h1234);
    chk(ccr_o == (exp_ccr | 8'h10), "R5 mask set", 32'(ccr_o), 32'(exp_ccr | 8'h10));
    chk(sp_o == exp_sp, "R4 sp after entry", 32'(sp_o), 32'(exp_sp));
    chk(x_o == ex && y_o == ey, "R7 index kept", {x_o, y_o}, {ex, ey});
    ccr_i = ccr_o;
    @(negedge clk);
    chk(ack_o == 1'b0, "R7 ack pulse", 32'(ack_o), 32'h0);
    chk(busy_o == 1'b0, "R8 no re-entry", 32'(busy_o), 32'h0);
  endtask

  task automatic wait_rti(input logic [15:0] epc, input logic [15:0] ex,
                          input logic [15:0] ey, input logic [7:0] ea,
                          input logic [7:0] eb, input logic [7:0] ec,
                          input logic [15:0] esp);
    do @(negedge clk); while (!ctx_wr_o);
    chk(pc_o == epc, "R10 pc", 32'(pc_o), 32'(epc));
    chk(x_o == ex && y_o == ey, "R10 x/y", {x_o, y_o}, {ex, ey});
    chk(a_o == ea && b_o == eb, "R10 a/b", {16'd0, a_o, b_o}, {16'd0, ea, eb});
    chk(ccr_o == ec, "R10 mask restore", 32'(ccr_o), 32'(ec));
    chk(ack_o == 1'b0, "R10 no ack", 32'(ack_o), 32'h0);
    chk(sp_o == esp, "R9 sp restored", 32'(sp_o), 32'(esp));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    mem[16'hFFF2] = 8'h12;
    mem[16'hFFF3] = 8'h34;
    rst_n = 1'b0; irq_n = 1'b1; inst_done = 1'b1; rti = 1'b0; sp_load = 1'b0;
    sp_din = '0; pc_i = '0; x_i = '0; y_i = '0; a_i = '0; b_i = '0; ccr_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !ack_o && !ctx_wr_o, "R1 flags", {busy_o, ack_o, ctx_wr_o}, 3'b000);
    chk(!mem_we_o && !mem_re_o, "R1 memory idle", {mem_we_o, mem_re_o}, 2'b00);
    chk(sp_o == 16'h0800, "R1 sp reset", 32'(sp_o), 32'h0800);

    // R12: load wins over a return strobe
    tick(); sp_load = 1'b1; sp_din = 16'h0400; rti = 1'b1;
    tick(); sp_load = 1'b0; rti = 1'b0;
    @(negedge clk);
    chk(sp_o == 16'h0400, "R12 sp load", 32'(sp_o), 32'h0400);
    chk(busy_o == 1'b0, "R12 no start", 32'(busy_o), 32'h0);

    // R2: single-cycle glitch
    tick(); irq_n = 1'b0;
    tick(); irq_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(busy_o == 1'b0, "R2 glitch", 32'(busy_o), 32'h0);
    end
    // R2: masked request
    tick(); ccr_i = 8'h10; irq_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(busy_o == 1'b0, "R2 masked", 32'(busy_o), 32'h0);
    end
    // R2: not at an instruction boundary
    tick(); ccr_i = 8'h05; inst_done = 1'b0;
    pc_i = 16'hA55A; x_i = 16'h1122; y_i = 16'h3344; a_i = 8'h5A; b_i = 8'hC3;
    repeat (3) begin
      @(negedge clk);
      chk(busy_o == 1'b0, "R2 boundary", 32'(busy_o), 32'h0);
    end
    exp_entry(16'h0400, 16'hA55A, 16'h1122, 16'h3344, 8'h5A, 8'hC3, 8'h05);
    tick(); inst_done = 1'b1;
    run_entry(16'h03F7, 8'h05, 16'h1122, 16'h3344);

    // R11: return and qualifying request in the same cycle
    tick(); irq_n = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(busy_o == 1'b0, "R2 masked in handler", 32'(busy_o), 32'h0);
    end
    exp_rti(16'h03F7);
    exp_entry(16'h0400, 16'h0F0E, 16'hBEEF, 16'hCAFE, 8'h01, 8'h80, 8'h45);
    tick();
    rti = 1'b1; ccr_i = 8'h45;
    pc_i = 16'h0F0E; x_i = 16'hBEEF; y_i = 16'hCAFE; a_i = 8'h01; b_i = 8'h80;
    tick(); rti = 1'b0;
    wait_rti(16'hA55A, 16'h1122, 16'h3344, 8'h5A, 8'hC3, 8'h05, 16'h0400);
    chk(q.size() == 11, "R11 return first", 32'(q.size()), 32'd11);
    run_entry(16'h03F7, 8'h45, 16'hBEEF, 16'hCAFE);

    // final return: X and I bits come back from the stack
    exp_rti(16'h03F7);
    tick(); rti = 1'b1;
    tick(); rti = 1'b0;
    wait_rti(16'h0F0E, 16'hBEEF, 16'hCAFE, 8'h01, 8'h80, 8'h45, 16'h0400);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3 all operations seen", 32'(q.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule